// File: doc/BRIEF.md
# Fractional Clock Divider with Update Handshake

The block divides an input clock by a factor made of an integer part and a fraction in steps of 1/512. The output frequency is Fin / (2 × (N + F/512)), where N is the integer factor and F is the 9-bit fraction. Each output half-period lasts N input cycles. One extra cycle is added whenever the fraction, summed into a 9-bit accumulator, carries out. This spreads the fractional part evenly over time by dithering.

Software places new factors on the factor inputs and pulses an update request. The block copies the factors into a staging register and raises a busy flag. At the next output half-period boundary it moves them into the active set and lowers the flag. Software polls the flag to learn that the new factors are in use. When the integer factor is zero, the fraction is ignored and the input clock is passed through undivided. Reset selects this bypass mode.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, upd_busy_o is 0 and the divider is in bypass, so clk_o equals clk_i.
- R2: While the active integer factor is 0, clk_o equals clk_i (high while clk_i is high, low while it is low), whatever fraction was supplied with it.
- R3: With active integer factor N ≥ 1 and fraction F, half-period number i (counted from 0 at the load) lasts N input cycles plus floor(i·F/512) − floor((i−1)·F/512) for i ≥ 1, and exactly N for i = 0.
- R4: Changing int_div_i or frac_div_i without an update request leaves the output half-period lengths unchanged.
- R5: A one-cycle pulse on upd_req_i while upd_busy_o is 0 makes upd_busy_o read 1 in the next cycle. The new factors govern the half-period that starts on the same edge on which upd_busy_o returns to 0.
- R6: An update request made while upd_busy_o is 1 is ignored. The factors captured by the first request are the ones applied.
- R7: New factors are applied only at an output half-period boundary. upd_busy_o stays 1 for at most L cycles, where L is the length of the half-period in progress (1 in bypass).
- R8: Loading new factors clears the dither accumulator, so the first half-period after a load lasts exactly N cycles. When leaving bypass, the divided output starts low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| int_div_i | input | INT_W | Integer divide factor to stage (0 selects bypass) |
| frac_div_i | input | 9 | Fractional divide factor in units of 1/512 |
| upd_req_i | input | 1 | Pulse to capture the factors and request their use |
| upd_busy_o | output | 1 | Update pending; cleared by hardware once the new factors are active |
| clk_o | output | 1 | Divided clock, or clk_i when bypassed |

## Verification
The assertions assume only that reset is applied at start-up; no timing restriction is placed on requests or factor values, because the staging register makes the block tolerant of either. The counter, toggle and handshake properties therefore hold for any input sequence. The stimulus still waits for upd_busy_o to fall before it measures, except in the one deliberate case where a second request is issued while the flag is high. It changes the factor inputs without a request only to show that they have no effect.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int FRAC_W   = 9;
    localparam int FRAC_SUM = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic              carry;
    } dither_t;

    function automatic dither_t dither_step(input logic [FRAC_W-1:0] acc,
                                            input logic [FRAC_W-1:0] frac);
        logic [FRAC_SUM-1:0] sum;
        dither_t             res;
        sum       = {1'b0, acc} + {1'b0, frac};
        res.acc   = sum[FRAC_W-1:0];
        res.carry = sum[FRAC_W];
        return res;
    endfunction

endpackage

// File: rtl/frac_div_stage.sv
module frac_div_stage
    import frac_div_pkg::*;
#(
    parameter int INT_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_div_i,
    input  logic              upd_req_i,
    input  logic              boundary_i,
    output logic              pending_o,
    output logic [INT_W-1:0]  stg_int_o,
    output logic [FRAC_W-1:0] stg_frac_o
);

    typedef struct packed {
        logic              pending;
        logic [INT_W-1:0]  int_div;
        logic [FRAC_W-1:0] frac_div;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pending) begin
            if (boundary_i) begin
                st_d.pending = 1'b0;
            end
        end else if (upd_req_i) begin
            st_d.pending  = 1'b1;
            st_d.int_div  = int_div_i;
            st_d.frac_div = (int_div_i == '0) ? '0 : frac_div_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o  = st_q.pending;
    assign stg_int_o  = st_q.int_div;
    assign stg_frac_o = st_q.frac_div;

    // R6: staged factors stay frozen while a request is outstanding
    assert_stage_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pending |=> $stable(st_q.int_div) && $stable(st_q.frac_div));

    // R7: pending only drops on a half-period boundary
    assert_clear_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pending && !boundary_i) |=> st_q.pending);

endmodule

// File: rtl/frac_div_core.sv
module frac_div_core
    import frac_div_pkg::*;
#(
    parameter int INT_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [INT_W-1:0]  new_int_i,
    input  logic [FRAC_W-1:0] new_frac_i,
    output logic              boundary_o,
    output logic              bypass_o,
    output logic              div_o
);

    typedef struct packed {
        logic [INT_W-1:0]  act_int;
        logic [FRAC_W-1:0] act_frac;
        logic [FRAC_W-1:0] acc;
        logic [INT_W-1:0]  cnt;
        logic              div;
    } core_t;

    core_t   cs_d, cs_q;
    dither_t step;
    logic    carry;
    logic [INT_W-1:0] next_int;

    assign boundary_o = (cs_q.cnt == '0);
    assign bypass_o   = (cs_q.act_int == '0);

    always_comb begin
        cs_d     = cs_q;
        step     = dither_step(cs_q.acc, cs_q.act_frac);
        carry    = 1'b0;
        next_int = cs_q.act_int;
        if (boundary_o) begin
            if (load_i) begin
                cs_d.act_int  = new_int_i;
                cs_d.act_frac = new_frac_i;
                cs_d.acc      = '0;
                next_int      = new_int_i;
            end else begin
                cs_d.acc = step.acc;
                carry    = step.carry;
            end
            cs_d.div = bypass_o ? 1'b0 : ~cs_q.div;
            if (next_int == '0) begin
                cs_d.div = 1'b0;
                cs_d.cnt = '0;
            end else begin
                cs_d.cnt = next_int - INT_W'(1) + INT_W'(carry);
            end
        end else begin
            cs_d.cnt = cs_q.cnt - INT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign div_o = cs_q.div;

    // R3: the half-period counter never exceeds the active integer factor
    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_q.cnt <= cs_q.act_int);

    // R2: in bypass the divided register rests low and idle
    assert_bypass_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_q.act_int == '0) |-> (!cs_q.div && cs_q.cnt == '0));

    // R7: output and factors change only at a boundary
    assert_mid_period_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_q.cnt != '0) |=> ($stable(cs_q.div) && $stable(cs_q.act_int) && $stable(cs_q.act_frac)));

    // R8: the accumulator restarts from zero on a load
    assert_acc_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && boundary_o) |=> (cs_q.acc == '0));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int INT_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_div_i,
    input  logic              upd_req_i,
    output logic              upd_busy_o,
    output logic              clk_o
);

    logic              pending;
    logic              boundary;
    logic              bypass;
    logic              div;
    logic [INT_W-1:0]  stg_int;
    logic [FRAC_W-1:0] stg_frac;

    frac_div_stage #(.INT_W(INT_W)) u_stage (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .int_div_i  (int_div_i),
        .frac_div_i (frac_div_i),
        .upd_req_i  (upd_req_i),
        .boundary_i (boundary),
        .pending_o  (pending),
        .stg_int_o  (stg_int),
        .stg_frac_o (stg_frac)
    );

    frac_div_core #(.INT_W(INT_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (pending),
        .new_int_i  (stg_int),
        .new_frac_i (stg_frac),
        .boundary_o (boundary),
        .bypass_o   (bypass),
        .div_o      (div)
    );

    assign upd_busy_o = pending;
    assign clk_o      = bypass ? clk_i : div;

    // R5: an accepted request shows as busy in the next cycle
    assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_req_i && !upd_busy_o) |=> upd_busy_o);

endmodule

// File: tb/frac_clk_div_test.sv
`timescale 1ns/1ps
module frac_clk_div_test;

    localparam int INT_W = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [INT_W-1:0] int_div = '0;
    logic [8:0]       frac_div = '0;
    logic             upd_req = 1'b0;
    logic             busy;
    logic             clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_n    = 0;

    always #10 clk = ~clk;

    frac_clk_div #(.INT_W(INT_W)) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .int_div_i  (int_div),
        .frac_div_i (frac_div),
        .upd_req_i  (upd_req),
        .upd_busy_o (busy),
        .clk_o      (clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int n, input int f, input int i);
        if (i == 0) return n;
        return n + (i * f) / 512 - ((i - 1) * f) / 512;
    endfunction

    // issue a request and wait for busy to clear; ends at the negedge where busy is 0
    task automatic update(input int n, input int f);
        int waited;
        int bound;
        bound = (cur_n == 0) ? 1 : cur_n + 1;
        @(negedge clk);
        int_div  = INT_W'(n);
        frac_div = 9'(f);
        upd_req  = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        check("R5 busy after request", int'(busy), 1);
        waited = 1;
        while (busy && waited < 100) begin
            @(negedge clk);
            if (busy) waited++;
        end
        check("R7 busy duration within bound", int'(waited <= bound), 1);
        cur_n = n;
    endtask

    // measure half-periods starting at the current negedge sample
    task automatic measure(input string req, input int n, input int f, input int halves);
        logic prev;
        int   run;
        int   idx;
        int   guard;
        prev  = clk_out;
        run   = 1;
        idx   = 0;
        guard = 0;
        while (idx < halves && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (clk_out == prev) begin
                run++;
            end else begin
                check(req, run, exp_len(n, f, idx));
                idx++;
                run  = 1;
                prev = clk_out;
            end
        end
        check({req, " completed"}, idx, halves);
    endtask

    task automatic check_bypass(input string req);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #5;
            check({req, " high phase"}, int'(clk_out), 1);
            @(negedge clk);
            #5;
            check({req, " low phase"}, int'(clk_out), 0);
        end
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy after reset", int'(busy), 0);
        check_bypass("R1 bypass after reset");

        // R8: leaving bypass starts low and lasts exactly N
        update(4, 0);
        check("R8 starts low", int'(clk_out), 0);
        measure("R8 first half after load", 4, 0, 6);

        // R3 sweep over integer and fraction
        for (int n = 1; n <= 6; n++) begin
            int fr [7] = '{0, 1, 128, 255, 256, 384, 511};
            for (int j = 0; j < 7; j++) begin
                update(n, fr[j]);
                measure("R3 dithered half-period", n, fr[j], 14);
            end
        end

        // R3 long run to show the accumulator wraps
        update(2, 300);
        measure("R3 long dither run", 2, 300, 40);

        // R4: factors changed without a request have no effect
        update(3, 0);
        int_div  = INT_W'(7);
        frac_div = 9'd200;
        measure("R4 inputs without request ignored", 3, 0, 8);

        // R6: second request while busy is ignored
        update(5, 0);
        @(negedge clk);
        int_div  = INT_W'(6);
        frac_div = 9'd0;
        upd_req  = 1'b1;
        @(negedge clk);
        upd_req  = 1'b0;
        check("R5 busy after request", int'(busy), 1);
        int_div  = INT_W'(2);
        frac_div = 9'd100;
        upd_req  = 1'b1;
        @(negedge clk);
        upd_req  = 1'b0;
        while (busy) @(negedge clk);
        cur_n = 6;
        measure("R6 later request ignored", 6, 0, 6);

        // R2: zero integer factor bypasses and ignores the fraction
        update(0, 137);
        check_bypass("R2 bypass with fraction");
        update(3, 64);
        measure("R5 new factors after bypass", 3, 64, 10);
        update(0, 0);
        check_bypass("R2 bypass plain");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule